// File: doc/BRIEF.md
# Privilege-Filtered Event Counter Slice

This block is one programmable hardware performance counter. Each cycle it may receive a one-cycle event pulse. It adds one to a 64-bit count when three conditions hold: the slot is available, the global inhibit for the slot is clear, and the privilege filter does not block the current execution mode. The filter uses five separate inhibit bits. The current privilege level and the virtualization flag select which of the five applies.

Software reaches the count through a half-word write port. Either 32-bit half can be loaded on its own, or both together. The count is presented as one 64-bit output. A small control word holds the five inhibit bits and a sticky overflow flag.

When the count wraps from all-ones to zero, the flag is set. A local overflow interrupt request is raised only if the flag was clear before the wrap. The request stays high until software acknowledges it.

All pins are plain control and status signals. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `perf_counter_slice`

## Requirements
- R1: While rst_n is low, count_o, ctl_o and irq_o all read zero. They stay zero after release until a write or an event changes them.
- R2: count_o rises by exactly one on the clock edge that samples event_i=1, provided avail_i=1, inhibit_i=0 and the filter does not block. With avail_i=0 or inhibit_i=1, the count stays unchanged.
- R3: With priv_i=2'b11 (machine), control bit 4 (machine inhibit) blocks counting, whatever the value of virt_i.
- R4: With priv_i=2'b01 (supervisor), control bit 3 blocks counting when virt_i=0, and control bit 1 blocks counting when virt_i=1. Each bit has no effect in the other virtualization state.
- R5: With priv_i=2'b00 (user), control bit 2 blocks counting when virt_i=0, and control bit 0 blocks counting when virt_i=1. Each bit has no effect in the other state. priv_i=2'b10 is never blocked.
- R6: The low half steps on every counted event. The high half steps only when the low half is all-ones. A counted event at all-ones wraps the whole count to zero.
- R7: cnt_we_i[0] loads count bits 31:0 from cnt_wdata_i[31:0], and cnt_we_i[1] loads bits 63:32 from cnt_wdata_i[63:32]. A half that is not written keeps its value. Any count write in a cycle suppresses that cycle's increment.
- R8: On a wrap with control bit 5 (overflow flag) clear, the flag reads 1 and irq_o reads 1 from the next cycle.
- R9: On a wrap with the overflow flag already set, irq_o does not rise and the flag stays set.
- R10: irq_o stays high until a cycle with irq_clr_i=1. irq_clr_i does not clear the overflow flag. Only a control write clears it.
- R11: ctl_we_i loads all six control bits from ctl_wdata_i, and ctl_o reads the stored word back in the next cycle. A wrap in the same cycle forces bit 5 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| event_i | input | 1 | One-cycle event pulse |
| priv_i | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine |
| virt_i | input | 1 | Virtualization active |
| avail_i | input | 1 | Slot is implemented and available |
| inhibit_i | input | 1 | Global inhibit for this slot |
| cnt_we_i | input | 2 | Half write enables, bit 0 low half, bit 1 high half |
| cnt_wdata_i | input | 64 | Count write data |
| count_o | output | 64 | Current count |
| ctl_we_i | input | 1 | Control word write enable |
| ctl_wdata_i | input | 6 | Control write data: 5 flag, 4 M, 3 S, 2 U, 1 VS, 0 VU |
| ctl_o | output | 6 | Stored control word |
| irq_clr_i | input | 1 | Acknowledge the pending interrupt |
| irq_o | output | 1 | Local overflow interrupt request |

## Verification
Reaching a wrap by counting events is impractical, because it would take 2^64 events. The hardest case to reach is a second wrap while the sticky flag is still set. The bench loads the count with all-ones (or the low half alone, to reach the carry into the high half), then pulses one event. For the second wrap it acknowledges the interrupt, leaves the flag set and reloads all-ones. It then checks that the request stays low. The five inhibit bits are each exercised in both virtualization states, so that a bit wired to the wrong mode shows up as a miscount.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  // Control word, bit 5 down to bit 0
  typedef struct packed {
    logic ovf;
    logic m_inh;
    logic s_inh;
    logic u_inh;
    logic vs_inh;
    logic vu_inh;
  } pcs_ctl_t;

  localparam int CTL_W = $bits(pcs_ctl_t);

  typedef enum logic [1:0] {
    PRIV_USER = 2'b00,
    PRIV_SUP  = 2'b01,
    PRIV_RSVD = 2'b10,
    PRIV_MACH = 2'b11
  } pcs_priv_e;
endpackage

// File: rtl/pcs_filter.sv
module pcs_filter
  import pcs_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic       m_inh_i,
  input  logic       s_inh_i,
  input  logic       u_inh_i,
  input  logic       vs_inh_i,
  input  logic       vu_inh_i,
  output logic       block_o
);
  always_comb begin
    unique case (pcs_priv_e'(priv_i))
      PRIV_MACH: block_o = m_inh_i;
      PRIV_SUP:  block_o = virt_i ? vs_inh_i : s_inh_i;
      PRIV_USER: block_o = virt_i ? vu_inh_i : u_inh_i;
      default:   block_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcs_counter.sv
module pcs_counter #(
  parameter int CNT_W  = 64,
  parameter int HALF_W = 32,
  localparam int NHALF = CNT_W / HALF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic [NHALF-1:0] we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [NHALF:0]   carry;
  logic [NHALF-1:0] ones;
  logic             go;

  assign go       = step_i && (we_i == '0);
  assign carry[0] = go;

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    logic [HALF_W-1:0] half_q;
    assign ones[g]    = &half_q;
    assign carry[g+1] = carry[g] & ones[g];
    assign cnt_o[g*HALF_W +: HALF_W] = half_q;

    always_ff @(posedge clk) begin
      if (!rst_n)        half_q <= '0;
      else if (we_i[g])  half_q <= wdata_i[g*HALF_W +: HALF_W];
      else if (carry[g]) half_q <= half_q + 1'b1;
    end

    AST_HALF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      we_i[g] |=> half_q == $past(wdata_i[g*HALF_W +: HALF_W])); // R7
  end

  assign wrap_o = carry[NHALF];

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> cnt_o == $past(cnt_o) + 1'b1); // R6
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> cnt_o == '0); // R6
endmodule

// File: rtl/pcs_ovf.sv
module pcs_ovf
  import pcs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wrap_i,
  input  logic     ctl_we_i,
  input  pcs_ctl_t ctl_wdata_i,
  input  logic     irq_clr_i,
  output pcs_ctl_t ctl_o,
  output logic     irq_o
);
  pcs_ctl_t ctl_q;
  logic     irq_q;
  logic     fresh;

  assign fresh = wrap_i && !ctl_q.ovf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      if (ctl_we_i) ctl_q <= ctl_wdata_i;
      if (wrap_i)   ctl_q.ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (fresh)     irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign ctl_o = ctl_q;
  assign irq_o = irq_q;

  AST_IRQ_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(wrap_i && !ctl_q.ovf)); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.ovf && !ctl_we_i |=> ctl_q.ovf); // R10
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !irq_clr_i |=> irq_q); // R10
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> ctl_q.ovf); // R8
endmodule

// File: rtl/perf_counter_slice.sv
module perf_counter_slice
  import pcs_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int HALF_W = 32,
  localparam int NHALF = CNT_W / HALF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             event_i,
  input  logic [1:0]       priv_i,
  input  logic             virt_i,
  input  logic             avail_i,
  input  logic             inhibit_i,
  input  logic [NHALF-1:0] cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  output logic [CNT_W-1:0] count_o,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CTL_W-1:0] ctl_o,
  input  logic             irq_clr_i,
  output logic             irq_o
);
  pcs_ctl_t ctl_q;
  logic     blocked;
  logic     step;
  logic     wrap;

  pcs_filter u_filter (
    .priv_i   (priv_i),
    .virt_i   (virt_i),
    .m_inh_i  (ctl_q.m_inh),
    .s_inh_i  (ctl_q.s_inh),
    .u_inh_i  (ctl_q.u_inh),
    .vs_inh_i (ctl_q.vs_inh),
    .vu_inh_i (ctl_q.vu_inh),
    .block_o  (blocked)
  );

  assign step = event_i && avail_i && !inhibit_i && !blocked;

  pcs_counter #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (step),
    .we_i    (cnt_we_i),
    .wdata_i (cnt_wdata_i),
    .cnt_o   (count_o),
    .wrap_o  (wrap)
  );

  pcs_ovf u_ovf (
    .clk         (clk),
    .rst_n       (rst_n),
    .wrap_i      (wrap),
    .ctl_we_i    (ctl_we_i),
    .ctl_wdata_i (pcs_ctl_t'(ctl_wdata_i)),
    .irq_clr_i   (irq_clr_i),
    .ctl_o       (ctl_q),
    .irq_o       (irq_o)
  );

  assign ctl_o = ctl_q;

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!avail_i || inhibit_i) && cnt_we_i == '0 |=> $stable(count_o)); // R2
  AST_MACH_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    priv_i == 2'b11 && ctl_o[4] && cnt_we_i == '0 |=> $stable(count_o)); // R3
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we_i == '1 |=> count_o == $past(cnt_wdata_i)); // R7
endmodule

// File: tb/perf_counter_slice_test.sv
module perf_counter_slice_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        event_i = 1'b0;
  logic [1:0]  priv_i = 2'b11;
  logic        virt_i = 1'b0;
  logic        avail_i = 1'b1;
  logic        inhibit_i = 1'b0;
  logic [1:0]  cnt_we_i = 2'b00;
  logic [63:0] cnt_wdata_i = '0;
  logic [63:0] count_o;
  logic        ctl_we_i = 1'b0;
  logic [5:0]  ctl_wdata_i = '0;
  logic [5:0]  ctl_o;
  logic        irq_clr_i = 1'b0;
  logic        irq_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  perf_counter_slice uut (
    .clk(clk), .rst_n(rst_n), .event_i(event_i), .priv_i(priv_i),
    .virt_i(virt_i), .avail_i(avail_i), .inhibit_i(inhibit_i),
    .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i), .count_o(count_o),
    .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i), .ctl_o(ctl_o),
    .irq_clr_i(irq_clr_i), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse();
    event_i = 1'b1; tick(); event_i = 1'b0;
  endtask

  task automatic wr_cnt(input logic [1:0] we, input logic [63:0] d);
    cnt_we_i = we; cnt_wdata_i = d; tick(); cnt_we_i = 2'b00;
  endtask

  task automatic wr_ctl(input logic [5:0] d);
    ctl_we_i = 1'b1; ctl_wdata_i = d; tick(); ctl_we_i = 1'b0;
  endtask

  task automatic t_reset();
    tick(); tick();
    chk(count_o == 0, "R1 count", count_o, 0);
    chk(ctl_o == 0, "R1 ctl", 64'(ctl_o), 0);
    chk(irq_o == 0, "R1 irq", 64'(irq_o), 0);
    rst_n = 1'b1; tick();
    chk(count_o == 0, "R1 after release", count_o, 0);
  endtask

  task automatic t_gates();
    logic [63:0] b;
    b = count_o; pulse(); pulse(); pulse();
    chk(count_o == b + 3, "R2 three events", count_o, b + 3);
    b = count_o; avail_i = 1'b0; pulse();
    chk(count_o == b, "R2 unavailable", count_o, b);
    avail_i = 1'b1; inhibit_i = 1'b1; pulse();
    chk(count_o == b, "R2 inhibited", count_o, b);
    inhibit_i = 1'b0; tick();
    chk(count_o == b, "R2 no event", count_o, b);
  endtask

  // one filter bit in one mode: blocked when virt == vblk, counts otherwise
  task automatic filt(input logic [5:0] bitv, input logic [1:0] pr,
                      input logic vblk, input logic both, input string req);
    logic [63:0] b;
    wr_ctl(bitv); priv_i = pr;
    virt_i = vblk; b = count_o; pulse();
    chk(count_o == b, {req, " blocked"}, count_o, b);
    virt_i = ~vblk; b = count_o; pulse();
    if (both) chk(count_o == b, {req, " blocked other virt"}, count_o, b);
    else      chk(count_o == b + 1, {req, " other virt counts"}, count_o, b + 1);
    virt_i = 1'b0;
  endtask

  task automatic t_filter();
    logic [63:0] b;
    filt(6'h10, 2'b11, 1'b0, 1'b1, "R3 machine");
    filt(6'h08, 2'b01, 1'b0, 1'b0, "R4 s_inh");
    filt(6'h02, 2'b01, 1'b1, 1'b0, "R4 vs_inh");
    filt(6'h04, 2'b00, 1'b0, 1'b0, "R5 u_inh");
    filt(6'h01, 2'b00, 1'b1, 1'b0, "R5 vu_inh");
    wr_ctl(6'h1f); priv_i = 2'b10; b = count_o; pulse();
    chk(count_o == b + 1, "R5 reserved priv", count_o, b + 1);
    wr_ctl(6'h00); priv_i = 2'b11;
    chk(ctl_o == 6'h00, "R11 ctl readback", 64'(ctl_o), 0);
  endtask

  task automatic t_halves();
    wr_cnt(2'b11, 64'h0000_0005_1234_5678);
    chk(count_o == 64'h0000_0005_1234_5678, "R7 full write", count_o, 64'h0000_0005_1234_5678);
    wr_cnt(2'b01, 64'h0000_0000_ffff_ffff);
    chk(count_o == 64'h0000_0005_ffff_ffff, "R7 low write", count_o, 64'h0000_0005_ffff_ffff);
    pulse();
    chk(count_o == 64'h0000_0006_0000_0000, "R6 carry into high", count_o, 64'h0000_0006_0000_0000);
    cnt_we_i = 2'b10; cnt_wdata_i = 64'h0000_0009_0000_0000; event_i = 1'b1;
    tick(); cnt_we_i = 2'b00; event_i = 1'b0;
    chk(count_o == 64'h0000_0009_0000_0000, "R7 write beats event", count_o, 64'h0000_0009_0000_0000);
  endtask

  task automatic t_wrap();
    wr_cnt(2'b11, '1);
    chk(irq_o == 0, "R8 no irq before wrap", 64'(irq_o), 0);
    pulse();
    chk(count_o == 0, "R6 wrap to zero", count_o, 0);
    chk(ctl_o[5] == 1, "R8 flag set", 64'(ctl_o), 64'h20);
    chk(irq_o == 1, "R8 irq raised", 64'(irq_o), 1);
    tick(); tick();
    chk(irq_o == 1, "R10 irq held", 64'(irq_o), 1);
    irq_clr_i = 1'b1; tick(); irq_clr_i = 1'b0;
    chk(irq_o == 0, "R10 irq cleared", 64'(irq_o), 0);
    chk(ctl_o[5] == 1, "R10 flag survives ack", 64'(ctl_o), 64'h20);
  endtask

  task automatic t_second_wrap();
    wr_cnt(2'b11, '1); pulse();
    chk(count_o == 0, "R9 second wrap count", count_o, 0);
    chk(irq_o == 0, "R9 no new irq", 64'(irq_o), 0);
    chk(ctl_o[5] == 1, "R9 flag stays", 64'(ctl_o), 64'h20);
    wr_ctl(6'h00);
    chk(ctl_o == 0, "R10 flag cleared by write", 64'(ctl_o), 0);
    wr_cnt(2'b11, '1); pulse();
    chk(irq_o == 1, "R8 irq after flag clear", 64'(irq_o), 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_gates();
    t_filter();
    t_halves();
    t_wrap();
    t_second_wrap();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule